// File: doc/BRIEF.md
# Banked Address Translation Unit

This block sits between a requester pair (a processor and a display-refresh DMA engine) and the external memory bus. It turns a 24-bit logical address into a 24-bit physical address by means of bank registers. Two fixed logical windows, here called the Y window (400000H to 5FFFFFH) and the Z window (800000H to 9FFFFFH), are each 200000H bytes wide. Inside a window the physical address is the selected bank number times the window size, plus the offset within the window. Addresses outside both windows go through unchanged.

Each window holds four bank registers, one for each kind of access: instruction fetch, data read, data write and display DMA read. The register in force is chosen from the window the address falls in and the access kind presented with it. Software loads the registers through a one-cycle write port. The active-low chip selects are decoded from the logical address, so a device keeps its own select whatever bank is mapped. A guard refuses to reload the fetch bank register of the window that code is currently being fetched from. Such a write is dropped and a sticky error flag is raised.

Top module: `bank_mmu`

## Requirements
- R1: After a synchronous reset every bank register is 0000H (enable clear, bank 0), so every address passes through unchanged, and `bank_err` is 0.
- R2: A Y-window access whose selected register has bit 15 set maps to physical = (bits 14:0 × 200000H + offset bits 20:0) truncated to 24 bits. For example, bank 1 at 400000H gives 200000H.
- R3: A Z-window access with its selected register loaded with 8000H (enabled, bank 0) maps 800000H to 000000H.
- R4: Access kind codes are fetch=0, read=1, write=2, DMA read=3. Configuration select `cfg_sel` = {window bit (0=Y, 1=Z), kind[1:0]}. Each window/kind pair uses only its own register.
- R5: A selected register with bit 15 clear leaves the address unchanged, whatever its bank field holds.
- R6: An address outside both windows leaves the physical address equal to the logical address.
- R7: While `req_valid` is high exactly one `cs_n` bit is low, decoded from the logical address: bit 0 below 400000H, bit 1 for the Y window, bit 2 for the Z window, bit 3 for anything else. While `req_valid` is low all four are high.
- R8: A register write takes effect on the clock edge at the end of its cycle. An access in the same cycle still sees the old value.
- R9: The window of the most recent valid fetch is remembered. A write to that window's fetch register is ignored, and `bank_err` rises on the next cycle.
- R10: `bank_err` stays high until reset. Writes to other registers are still accepted while it is high, and the guard follows the window of the latest fetch.
- R11: Bank numbers beyond the 24-bit range wrap. Bank 9 in the Y window gives the same physical address as bank 1, and bank 5 gives A00000H plus the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 DMA read |
| req_addr | input | 24 | Logical address |
| cfg_we | input | 1 | Bank register write strobe |
| cfg_sel | input | 3 | Register select {window, kind} |
| cfg_wdata | input | 16 | Register value: bit 15 enable, bits 14:0 bank |
| phys_addr | output | 24 | Translated physical address (combinational) |
| cs_n | output | 4 | Active-low chip selects from the logical address |
| bank_err | output | 1 | Sticky flag for a refused fetch-bank write |

## Verification
A wrong bank register value shows up on `phys_addr` in the very first access that selects that register. The offset bits stay correct, so a fault in the high bits points straight at the register or at the kind-to-register mapping. A stale or wrongly updated fetch-area tracker shows one cycle after a configuration write, either as a `bank_err` that should not have risen or as a fetch that translates with a bank value it should not have. Chip-select faults show in the same cycle as the access, because the decode is purely combinational.

// File: rtl/mmu_pkg.sv
// Package: shared types and constants for the banked address translation unit.
// Assumes four access kinds and a 16-bit bank register of {enable, bank[14:0]}.
package mmu_pkg;

    localparam int KIND_W    = 2;
    localparam int NUM_KINDS = 4;
    localparam int REG_W     = 16;
    localparam int BANK_W    = REG_W - 1;

    typedef enum logic [KIND_W-1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_DMA   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic              en;
        logic [BANK_W-1:0] bank;
    } bank_reg_t;

endpackage

// File: rtl/mmu_area_decode.sv
// Module: logical window hit detection and chip-select decode.
// Assumes windows are aligned to 2**WIN_LOG2, do not overlap, and the
// lowest window base is AREA_BASES[0]. Chip selects come from the logical address.
module mmu_area_decode #(
    parameter int ADDR_W    = 24,
    parameter int WIN_LOG2  = 21,
    parameter int NUM_AREAS = 2,
    parameter int AIDX_W    = 1,
    parameter logic [NUM_AREAS*ADDR_W-1:0] AREA_BASES = {24'h800000, 24'h400000}
) (
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 any_hit,
    output logic [AIDX_W-1:0]    area_idx,
    output logic [NUM_AREAS+1:0] cs_n
);

    localparam int NUM_CS = NUM_AREAS + 2;
    localparam int TAG_W  = ADDR_W - WIN_LOG2;
    localparam logic [ADDR_W-1:0] LOW_BASE = AREA_BASES[ADDR_W-1:0];

    logic [NUM_AREAS-1:0] hit;
    logic                 below_low;

    // one comparator per window on the address bits above the window size
    generate
        for (genvar a = 0; a < NUM_AREAS; a++) begin : g_hit
            localparam logic [ADDR_W-1:0] BASE = AREA_BASES[a*ADDR_W +: ADDR_W];
            assign hit[a] = (req_addr[ADDR_W-1:WIN_LOG2] == BASE[ADDR_W-1:ADDR_W-TAG_W]);
        end
    endgenerate

    assign any_hit   = |hit;
    assign below_low = (req_addr < LOW_BASE);

    // encode the hitting window to an index
    always_comb begin
        area_idx = '0;
        for (int a = 0; a < NUM_AREAS; a++) begin
            if (hit[a]) area_idx = AIDX_W'(a);
        end
    end

    // one-cold chip select: low region, one per window, then the remainder
    always_comb begin
        cs_n = '1;
        if (req_valid) begin
            if (below_low)    cs_n[0] = 1'b0;
            else if (any_hit) begin
                for (int a = 0; a < NUM_AREAS; a++) begin
                    if (hit[a]) cs_n[a+1] = 1'b0;
                end
            end
            else              cs_n[NUM_CS-1] = 1'b0;
        end
    end

endmodule

// File: rtl/mmu_bank_regs.sv
// Module: bank register file with fetch-area tracking and write guard.
// Assumes register index = {area index, kind}. A write to the fetch register
// of the window last fetched from is dropped and sets a sticky error.
module mmu_bank_regs
    import mmu_pkg::*;
#(
    parameter int NUM_AREAS = 2,
    parameter int AIDX_W    = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [AIDX_W+KIND_W-1:0]        cfg_sel,
    input  logic [REG_W-1:0]                cfg_wdata,
    input  logic                            fetch_stb,
    input  logic                            fetch_hit,
    input  logic [AIDX_W-1:0]               fetch_idx,
    output logic [NUM_AREAS*NUM_KINDS*REG_W-1:0] regs_flat,
    output logic                            guard_err
);

    localparam int NUM_REGS = NUM_AREAS * NUM_KINDS;
    localparam int SEL_W    = AIDX_W + KIND_W;

    logic              cur_valid;
    logic [AIDX_W-1:0] cur_idx;
    logic              blocked;
    logic              sel_is_fetch;

    assign sel_is_fetch = (acc_kind_e'(cfg_sel[KIND_W-1:0]) == ACC_FETCH);
    assign blocked = cfg_we && sel_is_fetch && cur_valid
                   && (cfg_sel[SEL_W-1:KIND_W] == cur_idx);

    // remember which window (if any) the latest valid fetch came from
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_idx   <= '0;
        end else if (fetch_stb) begin
            cur_valid <= fetch_hit;
            cur_idx   <= fetch_idx;
        end
    end

    // sticky flag for refused fetch-bank writes
    always_ff @(posedge clk) begin
        if (!rst_n)       guard_err <= 1'b0;
        else if (blocked) guard_err <= 1'b1;
    end

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            logic [REG_W-1:0] value_q;
            // load one bank register when selected and not refused
            always_ff @(posedge clk) begin
                if (!rst_n)
                    value_q <= '0;
                else if (cfg_we && !blocked && (cfg_sel == SEL_W'(r)))
                    value_q <= cfg_wdata;
            end
            assign regs_flat[r*REG_W +: REG_W] = value_q;
        end
    endgenerate

endmodule

// File: rtl/mmu_xlate.sv
// Module: combinational address translation.
// Assumes the caller supplies the window hit and index; the register in
// force is {area index, kind}; bank bits above the address width wrap away.
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int WIN_LOG2  = 21,
    parameter int NUM_AREAS = 2,
    parameter int AIDX_W    = 1
) (
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic [KIND_W-1:0]                    req_kind,
    input  logic                                 any_hit,
    input  logic [AIDX_W-1:0]                    area_idx,
    input  logic [NUM_AREAS*NUM_KINDS*REG_W-1:0] regs_flat,
    output logic [ADDR_W-1:0]                    phys_addr
);

    localparam int SEL_W = AIDX_W + KIND_W;

    logic [SEL_W-1:0] sel;
    bank_reg_t        active;

    assign sel    = {area_idx, req_kind};
    assign active = bank_reg_t'(regs_flat[sel*REG_W +: REG_W]);

    // bank * window size + offset when mapped, else the logical address
    always_comb begin
        if (any_hit && active.en)
            phys_addr = ADDR_W'({active.bank, {WIN_LOG2{1'b0}}})
                      | ADDR_W'(req_addr[WIN_LOG2-1:0]);
        else
            phys_addr = req_addr;
    end

endmodule

// File: rtl/bank_mmu.sv
// Module: top of the banked address translation unit.
// Assumes a single access per cycle, combinational translation, and two
// windows (Y then Z) of 2**WIN_LOG2 bytes at Y_BASE and Z_BASE.
module bank_mmu
    import mmu_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int WIN_LOG2 = 21,
    parameter logic [23:0] Y_BASE = 24'h400000,
    parameter logic [23:0] Z_BASE = 24'h800000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [3:0]        cs_n,
    output logic              bank_err
);

    localparam int NUM_AREAS = 2;
    localparam int AIDX_W    = 1;
    localparam logic [NUM_AREAS*ADDR_W-1:0] BASES =
        {ADDR_W'(Z_BASE), ADDR_W'(Y_BASE)};

    logic                                 any_hit;
    logic [AIDX_W-1:0]                    area_idx;
    logic [NUM_AREAS*NUM_KINDS*REG_W-1:0] regs_flat;
    logic                                 fetch_stb;

    assign fetch_stb = req_valid && (acc_kind_e'(req_kind) == ACC_FETCH);

    mmu_area_decode #(
        .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .NUM_AREAS(NUM_AREAS),
        .AIDX_W(AIDX_W), .AREA_BASES(BASES)
    ) decode_i (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .any_hit   (any_hit),
        .area_idx  (area_idx),
        .cs_n      (cs_n)
    );

    mmu_bank_regs #(
        .NUM_AREAS(NUM_AREAS), .AIDX_W(AIDX_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .fetch_stb (fetch_stb),
        .fetch_hit (any_hit),
        .fetch_idx (area_idx),
        .regs_flat (regs_flat),
        .guard_err (bank_err)
    );

    mmu_xlate #(
        .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .NUM_AREAS(NUM_AREAS),
        .AIDX_W(AIDX_W)
    ) xlate_i (
        .req_addr  (req_addr),
        .req_kind  (req_kind),
        .any_hit   (any_hit),
        .area_idx  (area_idx),
        .regs_flat (regs_flat),
        .phys_addr (phys_addr)
    );

endmodule

// File: rtl/bank_mmu_chk.sv
// Module: port-level property checker for bank_mmu, attached by bind.
// Assumes default window placement passed in through parameters.
module bank_mmu_chk #(
    parameter int ADDR_W   = 24,
    parameter int WIN_LOG2 = 21,
    parameter logic [23:0] Y_BASE = 24'h400000,
    parameter logic [23:0] Z_BASE = 24'h800000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-1:0] phys_addr,
    input logic [3:0]        cs_n,
    input logic              bank_err
);

    localparam logic [ADDR_W-1:0] Y_B = ADDR_W'(Y_BASE);
    localparam logic [ADDR_W-1:0] Z_B = ADDR_W'(Z_BASE);

    logic in_y, in_z;
    assign in_y = (req_addr[ADDR_W-1:WIN_LOG2] == Y_B[ADDR_W-1:WIN_LOG2]);
    assign in_z = (req_addr[ADDR_W-1:WIN_LOG2] == Z_B[ADDR_W-1:WIN_LOG2]);

    // R7: exactly one select low during an access
    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(~cs_n) == 1));

    // R7: no select when idle
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (cs_n == 4'b1111));

    // R7: window accesses pick their own select regardless of mapping
    a_r7_window_select: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (in_y || in_z)) |-> (cs_n[1] == !in_y && cs_n[2] == !in_z));

    // R2: the offset inside a window is never altered
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_y || in_z) |-> (phys_addr[WIN_LOG2-1:0] == req_addr[WIN_LOG2-1:0]));

    // R6: outside both windows the address passes through
    a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_y || in_z) |-> (phys_addr == req_addr));

    // R10: the error flag never falls while out of reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bank_err |=> bank_err);

endmodule

bind bank_mmu bank_mmu_chk #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .Y_BASE(Y_BASE), .Z_BASE(Z_BASE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .phys_addr (phys_addr),
    .cs_n      (cs_n),
    .bank_err  (bank_err)
);

// File: tb/bank_mmu_tb_top.sv
// Bench: scoreboard for bank_mmu. Driver steps push expected items, a
// monitor pops and compares them mid-cycle after each negedge drive.
module bank_mmu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [23:0] req_addr = 24'h0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [23:0] phys_addr;
    logic [3:0]  cs_n;
    logic        bank_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [23:0] phys;
        bit          chk_phys;
        logic [3:0]  cs;
        logic        err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    localparam logic [3:0] CS_LOW = 4'b1110;
    localparam logic [3:0] CS_Y   = 4'b1101;
    localparam logic [3:0] CS_Z   = 4'b1011;
    localparam logic [3:0] CS_HI  = 4'b0111;
    localparam logic [3:0] CS_OFF = 4'b1111;

    always #4 clk = ~clk;

    bank_mmu dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .phys_addr(phys_addr), .cs_n(cs_n),
        .bank_err(bank_err)
    );

    // driver: one cycle of stimulus plus its expected result
    task automatic step(input bit we, input logic [2:0] sel, input logic [15:0] wd,
                        input bit v, input logic [1:0] kind, input logic [23:0] addr,
                        input bit cp, input logic [23:0] ephys, input logic [3:0] ecs,
                        input logic eerr, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        req_valid = v; req_kind = kind; req_addr = addr;
        e.phys = ephys; e.chk_phys = cp; e.cs = ecs; e.err = eerr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: compare outputs two ns after each drive edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.chk_phys) begin
                    checks++;
                    if (phys_addr !== e.phys) begin
                        errors++;
                        $display("FAIL %s phys actual %h expected %h", e.tag, phys_addr, e.phys);
                    end
                end
                checks++;
                if (cs_n !== e.cs) begin
                    errors++;
                    $display("FAIL %s cs_n actual %b expected %b", e.tag, cs_n, e.cs);
                end
                checks++;
                if (bank_err !== e.err) begin
                    errors++;
                    $display("FAIL %s bank_err actual %b expected %b", e.tag, bank_err, e.err);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 / R7: idle, then reset state passes through
        step(0, 3'd0, 16'h0, 0, 2'd0, 24'h400000, 0, 24'h0, CS_OFF, 0, "R1 R7 idle");
        step(0, 3'd0, 16'h0, 1, 2'd1, 24'h400000, 1, 24'h400000, CS_Y, 0, "R1 reset passthru");
        // R8: Y write reg loaded, same-cycle access sees old value
        step(1, 3'd2, 16'h8001, 1, 2'd2, 24'h400010, 1, 24'h400010, CS_Y, 0, "R8 old value");
        // R2: bank 1 in Y
        step(0, 3'd0, 16'h0, 1, 2'd2, 24'h400000, 1, 24'h200000, CS_Y, 0, "R2 Y bank1");
        // R4: read and DMA registers still clear
        step(0, 3'd0, 16'h0, 1, 2'd1, 24'h400000, 1, 24'h400000, CS_Y, 0, "R4 read own reg");
        step(1, 3'd3, 16'h8001, 1, 2'd3, 24'h400000, 1, 24'h400000, CS_Y, 0, "R4 dma old");
        step(0, 3'd0, 16'h0, 1, 2'd3, 24'h412345, 1, 24'h212345, CS_Y, 0, "R4 dma bank1");
        // R3: Z read bank 0 enabled
        step(1, 3'd5, 16'h8000, 1, 2'd1, 24'h800000, 1, 24'h800000, CS_Z, 0, "R8 Z old");
        step(0, 3'd0, 16'h0, 1, 2'd1, 24'h800000, 1, 24'h000000, CS_Z, 0, "R3 Z bank0");
        // R5: enable clear, bank field ignored
        step(1, 3'd5, 16'h0001, 1, 2'd1, 24'h8ABCDE, 1, 24'h0ABCDE, CS_Z, 0, "R3 before disable");
        step(0, 3'd0, 16'h0, 1, 2'd1, 24'h8ABCDE, 1, 24'h8ABCDE, CS_Z, 0, "R5 disabled");
        // R6 / R7: outside windows
        step(0, 3'd0, 16'h0, 1, 2'd2, 24'h123456, 1, 24'h123456, CS_LOW, 0, "R6 R7 low region");
        step(0, 3'd0, 16'h0, 1, 2'd1, 24'hC00000, 1, 24'hC00000, CS_HI, 0, "R6 R7 high region");
        // R11: bank wrap
        step(1, 3'd1, 16'h8009, 0, 2'd0, 24'h0, 0, 24'h0, CS_OFF, 0, "R11 load");
        step(1, 3'd6, 16'h8005, 1, 2'd1, 24'h400100, 1, 24'h200100, CS_Y, 0, "R11 bank9 wraps");
        step(0, 3'd0, 16'h0, 1, 2'd2, 24'h801234, 1, 24'hA01234, CS_Z, 0, "R11 bank5");
        // R9: fetch guard
        step(1, 3'd0, 16'h8003, 0, 2'd0, 24'h0, 0, 24'h0, CS_OFF, 0, "R9 preload");
        step(0, 3'd0, 16'h0, 1, 2'd0, 24'h400004, 1, 24'h600004, CS_Y, 0, "R4 fetch bank3");
        step(1, 3'd0, 16'h8001, 0, 2'd0, 24'h0, 0, 24'h0, CS_OFF, 0, "R9 refused write");
        step(0, 3'd0, 16'h0, 1, 2'd0, 24'h400004, 1, 24'h600004, CS_Y, 1, "R9 write ignored");
        // R10: other writes accepted, flag sticks, guard follows latest fetch
        step(1, 3'd4, 16'h8001, 0, 2'd0, 24'h0, 0, 24'h0, CS_OFF, 1, "R10 Z fetch load");
        step(0, 3'd0, 16'h0, 1, 2'd0, 24'h800000, 1, 24'h200000, CS_Z, 1, "R10 Z fetch");
        step(1, 3'd0, 16'h8001, 0, 2'd0, 24'h0, 0, 24'h0, CS_OFF, 1, "R10 Y fetch load");
        step(0, 3'd0, 16'h0, 1, 2'd0, 24'h400004, 1, 24'h200004, CS_Y, 1, "R10 guard moved");
        step(0, 3'd0, 16'h0, 0, 2'd0, 24'h0, 0, 24'h0, CS_OFF, 1, "R10 still set");
        // R1: reset clears flag and registers
        do_reset();
        step(0, 3'd0, 16'h0, 1, 2'd2, 24'h400000, 1, 24'h400000, CS_Y, 0, "R1 after reset");
        step(0, 3'd0, 16'h0, 1, 2'd1, 24'h800000, 1, 24'h800000, CS_Z, 0, "R1 Z cleared");
        step(0, 3'd0, 16'h0, 0, 2'd0, 24'h0, 0, 24'h0, CS_OFF, 0, "R7 idle end");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule